// File: doc/BRIEF.md
# UART Transmit Flow-Control Gate

This block stands between a UART transmit buffer and the transmit shift register. Each cycle it decides whether the next buffered frame may move into the shift register, and it drives the request-to-send (RTS) pin. The load decision depends on the clear-to-send (CTS) handshake from the link partner and on a debug-halt request. The block only holds back the *next* frame. A frame that is already in the shift register always runs to completion, because the block never acts on the shift register itself.

A four-bit control register sets four things:
- whether CTS flow control is used;
- the polarity of the CTS pin;
- the polarity of the RTS pin;
- whether a debug halt stops transmission at the next frame boundary (and deasserts RTS) or lets the buffer drain.

CTS is asynchronous, so it is resynchronised before use. The buffer and the shift register are reached through two simple level signals: "buffer has a frame" and "shift register idle". The block answers with a one-cycle load strobe, which both pops the buffer and loads the shift register.

Top module: `uart_txgate`

## Requirements
- R1: A register write stores `reg_wr_data[3:0]` into the control bits. From the following cycle `reg_rd_data[3:0]` returns them. The bit layout is: bit 3 RTS invert, bit 2 CTS flow enable, bit 1 CTS invert, bit 0 halt-at-boundary. All four bits are 0 after reset.
- R2: `reg_rd_data[31:4]` always reads 0. Writing ones to those bits changes no readback bit and no behaviour.
- R3: When the RTS invert bit is 0, the asserted level of `rts_pin` is low. When the bit is 1, the asserted level is high. The deasserted level is always the opposite of the asserted level.
- R4: When the CTS invert bit is 0, `cts_pin` low counts as asserted. When the bit is 1, `cts_pin` high counts as asserted. A change on `cts_pin` reaches the load decision after exactly two rising clock edges.
- R5: When CTS flow control is enabled and synchronised CTS is not asserted, `load_o` stays 0.
- R6: When CTS flow control is disabled, `cts_pin` has no effect on `load_o`.
- R7: `load_o` is 1 only in a cycle where both `sh_idle` and `buf_nonempty` are 1. No load is issued while a frame is in progress.
- R8: When `dbg_halt_req` is 1 and the halt-at-boundary bit is 0, loading continues and RTS stays asserted.
- R9: When `dbg_halt_req` is 1 and the halt-at-boundary bit is 1, `load_o` is 0 in that same cycle. RTS is deasserted from the next clock edge for as long as the request lasts.
- R10: When the halt ends, RTS returns to its asserted level on the next clock edge. Loading resumes in the first cycle in which the load conditions hold.
- R11: During reset `load_o` is 0 and RTS is at its deasserted level. RTS is asserted from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write data |
| reg_rd_data | output | 32 | Control register read data |
| cts_pin | input | 1 | Clear-to-send pin from the link partner (asynchronous) |
| rts_pin | output | 1 | Request-to-send pin to the link partner |
| dbg_halt_req | input | 1 | Debug halt request from the core |
| buf_nonempty | input | 1 | Transmit buffer holds at least one frame |
| sh_idle | input | 1 | Transmit shift register is idle |
| load_o | output | 1 | One-cycle strobe: pop the buffer and load the shift register |

## Verification
The assertions check the following on every cycle:
- the load strobe appears only when the shift register is idle and the buffer has a frame;
- no load is issued and RTS is deasserted on the cycle after a halt that stops at the boundary;
- RTS sits at its asserted level whenever no such halt was requested;
- CTS is ignored when flow control is off;
- written control bits read back, and the reserved bits read 0.

Only the bench scenarios can show the following:
- the polarity sweep covering every combination of CTS and RTS inversion;
- the exact two-edge latency of the CTS synchroniser;
- the behaviour when a halt is released;
- the reset state seen from outside.

// File: rtl/uart_txgate_pkg.sv
package uart_txgate_pkg;

   localparam int CTRL_BITS = 4;

   // Field order (MSB first) matches the software-visible bit positions 3..0
   typedef struct packed {
      logic rts_inv;
      logic cts_en;
      logic cts_inv;
      logic halt_en;
   } txg_ctrl_t;

endpackage

// File: rtl/txg_ctrl_reg.sv
module txg_ctrl_reg
   import uart_txgate_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output txg_ctrl_t        ctrl,
   output logic [REG_W-1:0] rd_data
);
   localparam int RSV_W = REG_W - CTRL_BITS;

   initial begin
      if (REG_W <= CTRL_BITS) $error("txg_ctrl_reg: REG_W must exceed CTRL_BITS");
   end

   txg_ctrl_t ctrl_q;
   logic      unused_rsv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (wr_en)  ctrl_q <= txg_ctrl_t'(wr_data[CTRL_BITS-1:0]);
   end

   // Reserved write bits are discarded
   assign unused_rsv = ^wr_data[REG_W-1:CTRL_BITS];

   assign ctrl = ctrl_q;

   genvar gi;
   generate
      for (gi = 0; gi < REG_W; gi++) begin : g_rd
         if (gi < CTRL_BITS) begin : g_live
            assign rd_data[gi] = ctrl_q[gi];
         end else begin : g_rsv
            assign rd_data[gi] = 1'b0;
         end
      end
   endgenerate

   localparam int RSV_CHECK = RSV_W;
   initial begin
      if (RSV_CHECK < 0) $error("txg_ctrl_reg: negative reserved width");
   end
endmodule

// File: rtl/txg_sync.sv
module txg_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("txg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/txg_load_gate.sv
module txg_load_gate
   import uart_txgate_pkg::*;
(
   input  txg_ctrl_t ctrl,
   input  logic      cts_sync,
   input  logic      halt_req,
   input  logic      armed,
   input  logic      sh_idle,
   input  logic      buf_nonempty,
   output logic      load
);
   logic cts_asserted;
   logic cts_ok;
   logic halt_block;
   logic slot_open;

   always_comb begin
      cts_asserted = ctrl.cts_inv ? cts_sync : ~cts_sync;
      cts_ok       = ~ctrl.cts_en | cts_asserted;
      halt_block   = halt_req & ctrl.halt_en;
      slot_open    = sh_idle & buf_nonempty;
      load         = armed & slot_open & cts_ok & ~halt_block;
   end
endmodule

// File: rtl/txg_rts_drv.sv
module txg_rts_drv
   import uart_txgate_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  txg_ctrl_t ctrl,
   input  logic      halt_req,
   output logic      armed,
   output logic      rts_pin
);
   logic rts_active_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_active_q <= 1'b0;
         armed_q      <= 1'b0;
      end else begin
         rts_active_q <= ~(halt_req & ctrl.halt_en);
         armed_q      <= 1'b1;
      end
   end

   assign armed   = armed_q;
   assign rts_pin = ctrl.rts_inv ? rts_active_q : ~rts_active_q;
endmodule

// File: rtl/uart_txgate.sv
module uart_txgate
   import uart_txgate_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   input  logic             cts_pin,
   output logic             rts_pin,
   input  logic             dbg_halt_req,
   input  logic             buf_nonempty,
   input  logic             sh_idle,
   output logic             load_o
);
   initial begin
      if (REG_W < 8)        $error("uart_txgate: REG_W too small");
      if (SYNC_STAGES < 2)  $error("uart_txgate: SYNC_STAGES must be >= 2");
   end

   txg_ctrl_t ctrl;
   logic      cts_sync;
   logic      armed;

   txg_ctrl_reg #(.REG_W(REG_W)) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_data (reg_wr_data),
      .ctrl    (ctrl),
      .rd_data (reg_rd_data)
   );

   txg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_cts_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_pin),
      .q     (cts_sync)
   );

   txg_rts_drv i_rts (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl     (ctrl),
      .halt_req (dbg_halt_req),
      .armed    (armed),
      .rts_pin  (rts_pin)
   );

   txg_load_gate i_gate (
      .ctrl         (ctrl),
      .cts_sync     (cts_sync),
      .halt_req     (dbg_halt_req),
      .armed        (armed),
      .sh_idle      (sh_idle),
      .buf_nonempty (buf_nonempty),
      .load         (load_o)
   );
endmodule

// File: rtl/uart_txgate_chk.sv
module uart_txgate_chk #(
   parameter int REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [REG_W-1:0] reg_wr_data,
   input logic [REG_W-1:0] reg_rd_data,
   input logic             rts_pin,
   input logic             dbg_halt_req,
   input logic             buf_nonempty,
   input logic             sh_idle,
   input logic             load_o
);
   assert_wr_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> reg_rd_data[3:0] == $past(reg_wr_data[3:0]));

   assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[REG_W-1:4] == '0);

   assert_load_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> (sh_idle && buf_nonempty));

   assert_halt_noload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt_req && reg_rd_data[0]) |-> !load_o);

   assert_halt_rts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt_req && reg_rd_data[0]) |=> (rts_pin == !reg_rd_data[3]));

   assert_rts_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dbg_halt_req && reg_rd_data[0]) |=> (rts_pin == reg_rd_data[3]));

   assert_cts_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd_data[2] && !reg_rd_data[0] && sh_idle && buf_nonempty
       && $past(rst_n)) |-> load_o);
endmodule

bind uart_txgate uart_txgate_chk #(.REG_W(REG_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr_en    (reg_wr_en),
   .reg_wr_data  (reg_wr_data),
   .reg_rd_data  (reg_rd_data),
   .rts_pin      (rts_pin),
   .dbg_halt_req (dbg_halt_req),
   .buf_nonempty (buf_nonempty),
   .sh_idle      (sh_idle),
   .load_o       (load_o)
);

// File: tb/test_uart_txgate.sv
`timescale 1ns/1ps
module test_uart_txgate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic        cts_pin = 1'b1;
   logic        rts_pin;
   logic        dbg_halt_req = 1'b0;
   logic        buf_nonempty = 1'b0;
   logic        sh_idle = 1'b0;
   logic        load_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_txgate i_uart_txgate (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data), .cts_pin(cts_pin), .rts_pin(rts_pin),
      .dbg_halt_req(dbg_halt_req), .buf_nonempty(buf_nonempty),
      .sh_idle(sh_idle), .load_o(load_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [31:0] v);
      reg_wr_en   = 1'b1;
      reg_wr_data = v;
      @(negedge clk);
      reg_wr_en   = 1'b0;
      reg_wr_data = '0;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      sh_idle = 1'b1; buf_nonempty = 1'b1; cts_pin = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset readback", reg_rd_data, 32'h0);
      chk("R11 rts in reset", {31'b0, rts_pin}, 32'h1);
      chk("R11 load in reset", {31'b0, load_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rts after reset", {31'b0, rts_pin}, 32'h0);
      chk("R6 load after reset", {31'b0, load_o}, 32'h1);

      // R1 R2: all control values, reserved bits driven high
      for (int v = 0; v < 16; v++) begin
         write_ctrl(32'hFFFF_FFF0 | v);
         chk("R1 R2 readback", reg_rd_data, v);
      end
      write_ctrl(32'h0);

      // R4 synchroniser latency: enable CTS, active-low, pin high (not asserted)
      write_ctrl(32'h4);
      cts_pin = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 cts not asserted", {31'b0, load_o}, 32'h0);
      cts_pin = 1'b0;
      @(negedge clk);
      chk("R4 one edge after change", {31'b0, load_o}, 32'h0);
      @(negedge clk);
      chk("R4 two edges after change", {31'b0, load_o}, 32'h1);

      // Sweep: rts_inv, cts_en, cts_inv, halt_en, cts_pin, idle, nonempty, halt_req
      for (int m = 0; m < 256; m++) begin
         logic ri, ce, ci, he, cp, id, ne, hr, exp_load, act_rts, exp_rts;
         {ri, ce, ci, he, cp, id, ne, hr} = m[7:0];
         write_ctrl({28'h0, ri, ce, ci, he});
         cts_pin = cp; sh_idle = id; buf_nonempty = ne; dbg_halt_req = hr;
         repeat (3) @(negedge clk);
         exp_load = id & ne & (~ce | (ci ? cp : ~cp)) & ~(hr & he);
         act_rts  = ~(hr & he);
         exp_rts  = ri ? act_rts : ~act_rts;
         if (!id || !ne)
            chk("R7 no slot no load", {31'b0, load_o}, 32'h0);
         else if (hr && he)
            chk("R9 halt blocks load", {31'b0, load_o}, 32'h0);
         else if (hr && !he)
            chk("R8 halt ignored", {31'b0, load_o}, {31'b0, exp_load});
         else if (ce)
            chk("R4 R5 cts gated load", {31'b0, load_o}, {31'b0, exp_load});
         else
            chk("R6 cts ignored", {31'b0, load_o}, {31'b0, exp_load});
         if (hr && he)
            chk("R9 R3 rts deasserted", {31'b0, rts_pin}, {31'b0, exp_rts});
         else
            chk("R3 R8 rts asserted", {31'b0, rts_pin}, {31'b0, exp_rts});
      end

      // R9 R10 halt entry/exit timing, RTS inverted
      dbg_halt_req = 1'b0; sh_idle = 1'b1; buf_nonempty = 1'b1; cts_pin = 1'b0;
      write_ctrl(32'h9);
      repeat (3) @(negedge clk);
      chk("R3 inverted rts asserted", {31'b0, rts_pin}, 32'h1);
      dbg_halt_req = 1'b1;
      #1;
      chk("R9 same-cycle load block", {31'b0, load_o}, 32'h0);
      chk("R9 rts before edge", {31'b0, rts_pin}, 32'h1);
      @(negedge clk);
      chk("R9 rts after edge", {31'b0, rts_pin}, 32'h0);
      dbg_halt_req = 1'b0;
      #1;
      chk("R10 load resumes", {31'b0, load_o}, 32'h1);
      chk("R10 rts before edge", {31'b0, rts_pin}, 32'h0);
      @(negedge clk);
      chk("R10 rts restored", {31'b0, rts_pin}, 32'h1);

      // R7 frame in progress: CTS drops mid-frame, no load while busy or after
      write_ctrl(32'h4);
      sh_idle = 1'b0;
      cts_pin = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 busy no load", {31'b0, load_o}, 32'h0);
      sh_idle = 1'b1;
      #1;
      chk("R5 idle cts off no load", {31'b0, load_o}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule